// File: doc/BRIEF.md
# Subroutine Call Sequencer

This block is the multi-cycle control unit that carries out a call-to-subroutine for a small 8-bit processor with a 16-bit program counter. Once instruction fetch has collected the opcode and up to two operand bytes, it raises `start` for one cycle. The block decodes the addressing mode and latches the operands, the index register and the current program counter. It then computes the return address and the target address. It writes the return address onto a stack that grows downward, one byte per cycle, through a byte-wide write port. In the final cycle it hands the target to the program counter.

The stack lives in a fixed 256-byte page whose upper address byte is the parameter `STACK_PAGE`. The stack pointer is an 8-bit register inside the block, it wraps modulo 256, and it is visible on `sp_o`. An opcode the block does not recognise raises a one-cycle error pulse and leaves every register as it was.

The state machine has six states. IDLE waits for `start`. CALC registers the address arithmetic. PUSH_LO writes the low return byte. PUSH_HI writes the high return byte. WAIT pads the sequence to the length set by the addressing mode. LOAD asserts `done` and `pc_we`. The transitions are:
- IDLE→CALC on `start` with a known opcode.
- CALC→PUSH_LO and PUSH_LO→PUSH_HI, each unconditionally.
- PUSH_HI→LOAD or PUSH_HI→WAIT, depending on whether the cycle budget is already spent.
- WAIT→WAIT until the budget is spent, then WAIT→LOAD.
- LOAD→IDLE.

Top module: `jsr_sequencer`

## Requirements
- R1: With `start` high in IDLE, the opcodes 0xBD (direct), 0xCD (extended), 0xDD (indexed, 16-bit offset), 0xED (indexed, 8-bit offset) and 0xFD (indexed, no offset) are accepted. The next cycle has `busy` high.
- R2: The return address is `pc_i` plus the instruction length, modulo 2^16. The length is 1 for no-offset indexed, 2 for direct and 8-bit-offset indexed, and 3 for extended and 16-bit-offset indexed. `pc_i` is the address of the opcode byte.
- R3: The cycle of acceptance is cycle 1. In cycle 3 `mem_we` is high with the low return byte at address {STACK_PAGE, sp}. In cycle 4 `mem_we` is high with the high return byte at {STACK_PAGE, sp-1}. `mem_we` is low in every other cycle.
- R4: The stack pointer drops by one after each write, so it ends two lower than it started. It wraps from 0x00 to 0xFF within the page. After reset it holds SP_INIT (0xFF).
- R5: `done` is high in exactly one cycle. That cycle is cycle 5 for direct, 6 for extended, 7 for 16-bit-offset indexed, 6 for 8-bit-offset indexed and 5 for no-offset indexed. `busy` is high from cycle 2 through that cycle.
- R6: In the `done` cycle, `pc_we` is high and `pc_o` carries the target address. The next cycle is IDLE.
- R7: The target address depends on the mode:
  - direct: {0x00, opnd1}
  - extended: {opnd1, opnd2}
  - 16-bit-offset indexed: {opnd1, opnd2} + x_reg, modulo 2^16
  - 8-bit-offset indexed: opnd1 + x_reg, zero-extended to 16 bits
  - no-offset indexed: {0x00, x_reg}
- R8: `start` with any other opcode in IDLE makes `err` high in the following cycle only. That cycle has no write, `busy` stays low, and `sp_o` is unchanged.
- R9: `start` and changes on the operand inputs while `busy` is high have no effect on the running sequence.
- R10: While and after reset, `busy`, `mem_we`, `done`, `pc_we` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a call with the presented opcode |
| opcode | input | 8 | Fetched opcode |
| opnd1 | input | 8 | First operand byte (address high for two-byte forms) |
| opnd2 | input | 8 | Second operand byte |
| x_reg | input | 8 | Index register value |
| pc_i | input | 16 | Address of the opcode byte |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Unrecognised opcode pulse |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| pc_we | output | 1 | Program counter load strobe |
| pc_o | output | 16 | New program counter value |
| done | output | 1 | Final cycle of the call |
| sp_o | output | 8 | Current stack pointer |

## Verification
Counting the acceptance cycle as cycle 1:
- The two stack writes are due in cycles 3 and 4.
- The stack pointer reads one lower from cycle 4 and two lower from cycle 5.
- `done` with the target address is due in cycle 5, 6 or 7, depending on the mode.
- An error pulse is due one cycle after the rejected `start`.

The bench's reference model turns each call into a timeline of expected values indexed by that cycle number. It samples every output at the falling edge of each cycle and compares it against the timeline, including the idle cycle after `done`.

// File: rtl/jsr_pkg.sv
package jsr_pkg;

    typedef enum logic [2:0] {
        MODE_DIR,
        MODE_EXT,
        MODE_IX2,
        MODE_IX1,
        MODE_IX0
    } call_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_WAIT,
        ST_LOAD
    } call_state_t;

    localparam logic [7:0] OPC_DIR = 8'hBD;
    localparam logic [7:0] OPC_EXT = 8'hCD;
    localparam logic [7:0] OPC_IX2 = 8'hDD;
    localparam logic [7:0] OPC_IX1 = 8'hED;
    localparam logic [7:0] OPC_IX0 = 8'hFD;

    localparam int LEN_W = 2;
    localparam int CYC_W = 3;

endpackage

// File: rtl/jsr_decode.sv
module jsr_decode
    import jsr_pkg::*;
(
    input  logic [7:0]       opcode,
    output logic             valid,
    output call_mode_t       mode,
    output logic [LEN_W-1:0] len,
    output logic [CYC_W-1:0] cycles
);

    always_comb begin
        valid  = 1'b1;
        mode   = MODE_DIR;
        len    = LEN_W'(2);
        cycles = CYC_W'(5);
        unique case (opcode)
            OPC_DIR: begin mode = MODE_DIR; len = LEN_W'(2); cycles = CYC_W'(5); end
            OPC_EXT: begin mode = MODE_EXT; len = LEN_W'(3); cycles = CYC_W'(6); end
            OPC_IX2: begin mode = MODE_IX2; len = LEN_W'(3); cycles = CYC_W'(7); end
            OPC_IX1: begin mode = MODE_IX1; len = LEN_W'(2); cycles = CYC_W'(6); end
            OPC_IX0: begin mode = MODE_IX0; len = LEN_W'(1); cycles = CYC_W'(5); end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/jsr_addr_unit.sv
module jsr_addr_unit
    import jsr_pkg::*;
#(
    parameter int DW = 8
) (
    input  call_mode_t        mode,
    input  logic [LEN_W-1:0]  len,
    input  logic [2*DW-1:0]   pc,
    input  logic [DW-1:0]     op1,
    input  logic [DW-1:0]     op2,
    input  logic [DW-1:0]     xr,
    output logic [2*DW-1:0]   target,
    output logic [2*DW-1:0]   ret_addr
);

    localparam int AW = 2 * DW;

    logic [AW-1:0] x_ext;
    logic [AW-1:0] op1_ext;
    logic [AW-1:0] pair;

    assign x_ext   = AW'(xr);
    assign op1_ext = AW'(op1);
    assign pair    = {op1, op2};

    assign ret_addr = pc + AW'(len);

    always_comb begin
        unique case (mode)
            MODE_DIR: target = op1_ext;
            MODE_EXT: target = pair;
            MODE_IX2: target = pair + x_ext;
            MODE_IX1: target = op1_ext + x_ext;
            MODE_IX0: target = x_ext;
            default:  target = '0;
        endcase
    end

endmodule

// File: rtl/jsr_stack_ptr.sv
module jsr_stack_ptr #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] SP_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec,
    output logic [DW-1:0] sp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= SP_INIT;
        end else if (dec) begin
            sp <= sp - DW'(1);
        end
    end

endmodule

// File: rtl/jsr_sequencer.sv
module jsr_sequencer
    import jsr_pkg::*;
#(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [DW-1:0] SP_INIT    = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     opcode,
    input  logic [DW-1:0]     opnd1,
    input  logic [DW-1:0]     opnd2,
    input  logic [DW-1:0]     x_reg,
    input  logic [2*DW-1:0]   pc_i,
    output logic              busy,
    output logic              err,
    output logic              mem_we,
    output logic [2*DW-1:0]   mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              pc_we,
    output logic [2*DW-1:0]   pc_o,
    output logic              done,
    output logic [DW-1:0]     sp_o
);

    localparam int AW    = 2 * DW;
    localparam int STEP_W = CYC_W;

    call_state_t state_q, state_d;

    logic             dec_valid;
    call_mode_t       dec_mode;
    logic [LEN_W-1:0] dec_len;
    logic [CYC_W-1:0] dec_cycles;

    call_mode_t       mode_q;
    logic [LEN_W-1:0] len_q;
    logic [CYC_W-1:0] cyc_q;
    logic [STEP_W-1:0] step_q;
    logic [DW-1:0]    op1_q, op2_q, x_q;
    logic [AW-1:0]    pc_q;
    logic [AW-1:0]    ea_c, ret_c;
    logic [AW-1:0]    ea_q, ret_q;
    logic             err_q;
    logic             accept;
    logic             budget_spent;
    logic             sp_dec;
    logic [DW-1:0]    sp;

    jsr_decode u_decode (
        .opcode (opcode),
        .valid  (dec_valid),
        .mode   (dec_mode),
        .len    (dec_len),
        .cycles (dec_cycles)
    );

    jsr_addr_unit #(.DW(DW)) u_addr (
        .mode     (mode_q),
        .len      (len_q),
        .pc       (pc_q),
        .op1      (op1_q),
        .op2      (op2_q),
        .xr       (x_q),
        .target   (ea_c),
        .ret_addr (ret_c)
    );

    jsr_stack_ptr #(.DW(DW), .SP_INIT(SP_INIT)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .sp    (sp)
    );

    assign accept       = (state_q == ST_IDLE) && start && dec_valid;
    // step_q is (cycle number - 2); leave for LOAD when the next cycle is the last
    assign budget_spent = (step_q == STEP_W'(cyc_q - CYC_W'(3)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_CALC;
            ST_CALC:    state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = budget_spent ? ST_LOAD : ST_WAIT;
            ST_WAIT:    state_d = budget_spent ? ST_LOAD : ST_WAIT;
            ST_LOAD:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_DIR;
            len_q  <= '0;
            cyc_q  <= '0;
            step_q <= '0;
            op1_q  <= '0;
            op2_q  <= '0;
            x_q    <= '0;
            pc_q   <= '0;
            ea_q   <= '0;
            ret_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= (state_q == ST_IDLE) && start && !dec_valid;
            if (accept) begin
                mode_q <= dec_mode;
                len_q  <= dec_len;
                cyc_q  <= dec_cycles;
                step_q <= '0;
                op1_q  <= opnd1;
                op2_q  <= opnd2;
                x_q    <= x_reg;
                pc_q   <= pc_i;
            end else if (state_q != ST_IDLE) begin
                step_q <= step_q + STEP_W'(1);
            end
            if (state_q == ST_CALC) begin
                ea_q  <= ea_c;
                ret_q <= ret_c;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_we    = 1'b0;
        mem_wdata = ret_q[DW-1:0];
        done      = 1'b0;
        pc_we     = 1'b0;
        unique case (state_q)
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_wdata = ret_q[DW-1:0];
            end
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_wdata = ret_q[AW-1:DW];
            end
            ST_LOAD: begin
                done  = 1'b1;
                pc_we = 1'b1;
            end
            default: ;
        endcase
    end

    assign sp_dec   = mem_we;
    assign mem_addr = {STACK_PAGE, sp};
    assign pc_o     = ea_q;
    assign sp_o     = sp;
    assign err      = err_q;

endmodule

// File: rtl/jsr_checker.sv
module jsr_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          err,
    input logic          mem_we,
    input logic [DW-1:0] addr_lo,
    input logic          done,
    input logic [DW-1:0] sp_o,
    input logic [2:0]    cyc_q
);

    logic [3:0]    busy_cnt;
    logic [DW-1:0] sp_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            sp_idle  <= '0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 4'd1 : 4'd0;
            if (!busy) sp_idle <= sp_o;
        end
    end

    assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |=> (mem_we && addr_lo == DW'($past(addr_lo) - 1'b1)));

    assert_two_pushes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |=> !mem_we);

    assert_sp_net_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_cnt != 4'd0) |-> (sp_o == DW'(sp_idle - 2'd2)));

    assert_cycle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_cnt != 4'd0) |-> (busy_cnt == ({1'b0, cyc_q} - 4'd2)));

    assert_back_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !mem_we && $stable(sp_o)));

    assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

endmodule

bind jsr_sequencer jsr_checker #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .err     (err),
    .mem_we  (mem_we),
    .addr_lo (mem_addr[DW-1:0]),
    .done    (done),
    .sp_o    (sp_o),
    .cyc_q   (cyc_q)
);

// File: tb/jsr_sequencer_test.sv
module jsr_sequencer_test;

    localparam logic [7:0] PAGE = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, opnd1 = 8'h00, opnd2 = 8'h00, x_reg = 8'h00;
    logic [15:0] pc_i = 16'h0000;
    logic        busy, err, mem_we, pc_we, done;
    logic [15:0] mem_addr, pc_o;
    logic [7:0]  mem_wdata, sp_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [7:0] model_sp = 8'hFF;

    always #4 clk = ~clk;

    jsr_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .opnd1(opnd1), .opnd2(opnd2), .x_reg(x_reg), .pc_i(pc_i),
        .busy(busy), .err(err), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_we(pc_we), .pc_o(pc_o), .done(done),
        .sp_o(sp_o)
    );

    task automatic check_quiet(string tag, logic exp_err, logic [7:0] exp_sp);
        checks++;
        if (busy !== 1'b0 || mem_we !== 1'b0 || done !== 1'b0 || pc_we !== 1'b0 ||
            err !== exp_err || sp_o !== exp_sp) begin
            fails++;
            $display("FAIL %s: busy=%b we=%b done=%b pc_we=%b err=%b sp=%h expected 0 0 0 0 err=%b sp=%h",
                     tag, busy, mem_we, done, pc_we, err, sp_o, exp_err, exp_sp);
        end
    endtask

    // behavioural reference: expected outputs for cycle c of an n-cycle call
    task automatic check_cycle(int c, int n, logic [7:0] sp0, logic [15:0] ret,
                               logic [15:0] ea, string tag);
        logic eb, ew, ed, ok;
        logic [7:0]  es, edata;
        logic [15:0] eaddr;
        eb = (c >= 2 && c <= n);
        ew = (c == 3 || c == 4);
        ed = (c == n);
        es = (c <= 3) ? sp0 : (c == 4) ? sp0 - 8'd1 : sp0 - 8'd2;
        eaddr = {PAGE, (c == 3) ? sp0 : sp0 - 8'd1};
        edata = (c == 3) ? ret[7:0] : ret[15:8];
        ok = (busy === eb) && (mem_we === ew) && (done === ed) && (pc_we === ed) &&
             (sp_o === es) && (err === 1'b0);
        if (ew) ok = ok && (mem_addr === eaddr) && (mem_wdata === edata);
        if (ed) ok = ok && (pc_o === ea);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d (R1 R2 R3 R4 R5 R6 R7): busy=%b we=%b addr=%h data=%h done=%b pc_we=%b pc=%h sp=%h err=%b expected busy=%b we=%b addr=%h data=%h done=%b pc=%h sp=%h",
                     tag, c, busy, mem_we, mem_addr, mem_wdata, done, pc_we, pc_o, sp_o, err,
                     eb, ew, eaddr, edata, ed, ea, es);
        end
    endtask

    task automatic do_call(logic [7:0] opc, logic [7:0] b1, logic [7:0] b2,
                           logic [7:0] xv, logic [15:0] pc, bit meddle, string tag);
        int len, n;
        logic [15:0] ea, ret;
        logic [7:0]  sp0;
        case (opc)
            8'hBD: begin len = 2; n = 5; ea = {8'h00, b1}; end
            8'hCD: begin len = 3; n = 6; ea = {b1, b2}; end
            8'hDD: begin len = 3; n = 7; ea = {b1, b2} + {8'h00, xv}; end
            8'hED: begin len = 2; n = 6; ea = {8'h00, b1} + {8'h00, xv}; end
            default: begin len = 1; n = 5; ea = {8'h00, xv}; end
        endcase
        ret = pc + 16'(len);
        sp0 = model_sp;
        @(negedge clk);
        start = 1'b1; opcode = opc; opnd1 = b1; opnd2 = b2; x_reg = xv; pc_i = pc;
        check_cycle(1, n, sp0, ret, ea, tag);
        for (int c = 2; c <= n + 1; c++) begin
            @(negedge clk);
            if (c == 2) begin
                if (meddle) begin
                    // R9: new start and changed operands while busy
                    start = 1'b1; opcode = 8'hCD; opnd1 = ~b1; opnd2 = ~b2;
                    x_reg = ~xv; pc_i = ~pc;
                end else begin
                    start = 1'b0;
                end
            end
            check_cycle(c, n, sp0, ret, ea, tag);
            if (c == n) start = 1'b0;
        end
        model_sp = sp0 - 8'd2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R10 during reset", 1'b0, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R10 after reset", 1'b0, 8'hFF);

        do_call(8'hBD, 8'h40, 8'h99, 8'h11, 16'h1234, 1'b0, "R1 R7 direct");
        do_call(8'hCD, 8'h8A, 8'h5C, 8'h22, 16'h2000, 1'b0, "R1 R7 extended");
        do_call(8'hCD, 8'h12, 8'h34, 8'h00, 16'hFFFE, 1'b0, "R2 return wraps");
        do_call(8'hDD, 8'hFF, 8'hF0, 8'h20, 16'h0300, 1'b0, "R7 ix16 wraps");
        do_call(8'hDD, 8'h30, 8'h00, 8'h05, 16'h0400, 1'b0, "R7 ix16");
        do_call(8'hED, 8'hF0, 8'h00, 8'h20, 16'h0500, 1'b0, "R7 ix8 carry");
        do_call(8'hFD, 8'h00, 8'h00, 8'h7F, 16'h0600, 1'b0, "R7 ix0");
        do_call(8'hBD, 8'h55, 8'h66, 8'h77, 16'h0700, 1'b1, "R9 start while busy");

        // R8: unknown opcode
        @(negedge clk);
        start = 1'b1; opcode = 8'hAD;
        @(negedge clk);
        start = 1'b0;
        check_quiet("R8 error pulse", 1'b1, model_sp);
        @(negedge clk);
        check_quiet("R8 error clears", 1'b0, model_sp);

        // R4: run the pointer around the page
        while (model_sp != 8'h01) begin
            do_call(8'hFD, 8'h00, 8'h00, model_sp, 16'h0800, 1'b0, "R4 fill");
        end
        do_call(8'hED, 8'h10, 8'h00, 8'h01, 16'h0900, 1'b0, "R4 push at 01 and 00");
        do_call(8'hBD, 8'h21, 8'h00, 8'h00, 16'h0A00, 1'b0, "R4 wrapped to FF");

        @(negedge clk);
        check_quiet("R10 idle at end", 1'b0, model_sp);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule